// File: doc/BRIEF.md
# Remote Control Custom Code Resolver

This block works out the 16-bit custom code of an infrared remote control transmitter from board straps. After a start request it drives eight select lines one at a time. While a line is driven it reads two logic-level inputs. The first is a shared code-select return, which shows whether that line is wired to the common select net. The second is a strap indication, which shows whether that line has a pull-up fitted.

When all eight lines have been read, the block builds a primary byte and a check byte. It uses one of two schemes, chosen by a scheme input.

- **Matrix scheme:** each primary bit records its line's connection directly.
- **Select scheme:** the primary byte is decoded from which single line is connected, together with a small table indexed by two straps.

In both schemes, each check bit is either a plain copy or an inverted copy of the matching primary bit, controlled by a strap. The resolved code is then held with a valid flag until the next start.

The scan is a five-state machine:

- `ST_IDLE` waits after reset. The transition *accept* (start seen in `ST_IDLE` or `ST_DONE`) goes to `ST_SETTLE` at line 0.
- `ST_SETTLE` drives the current line for one cycle, then takes *settle_done* to `ST_SAMPLE`.
- `ST_SAMPLE` drives the same line and captures both inputs. It then takes *next_line* back to `ST_SETTLE` with the index incremented, or, on line 7, *last_line* to `ST_RESOLVE`.
- `ST_RESOLVE` loads the output registers and takes *publish* to `ST_DONE`.
- `ST_DONE` holds the result until the next *accept*.

Top module: `cc_resolver`

## Requirements
- R1: While reset is held and right after it, `line_drive`, `code_hi`, `code_lo`, `code_valid` and `multi_conn_err` are all zero.
- R2: After an accepted start, line k (bit k of `line_drive`, k = 0..7 in ascending order) is the only line driven, for exactly two consecutive cycles. `line_drive` is zero whenever no scan is running.
- R3: `code_valid` falls on the clock edge that accepts a start and rises exactly 17 edges later. After that it stays high with `code_hi`/`code_lo` unchanged until the next accepted start.
- R4: Matrix scheme (`scheme_sel` = 0): bit n of `code_hi` is 1 exactly when `code_sel_in` was high while line n was driven.
- R5: Matrix scheme: bit n of `code_lo` equals bit n of `code_hi` when the strap of line n read 1, and its inverse when that strap read 0. For example, hi 0x51 with straps 0x11 gives lo 0xBF.
- R6: Select scheme (`scheme_sel` = 1): `code_hi[2:0]` is the binary index of the line on which `code_sel_in` read high, and 000 when no line read high.
- R7: Select scheme: `code_hi[7:3]` is taken from the straps of lines 7 and 6. Neither strap gives 00000. Line 7 only gives 10011. Line 6 only gives 10001. Both give 11101.
- R8: Select scheme: `code_lo[n]` follows the R5 copy/invert rule using the strap of line n for n = 0..5. Bits 6 and 7 of `code_lo` are always the inverse of the matching `code_hi` bits.
- R9: Select scheme with more than one line reading high: the lowest index sets `code_hi[2:0]` and `multi_conn_err` is 1. Otherwise, and always in the matrix scheme, `multi_conn_err` is 0.
- R10: `scheme_sel` is latched on the accepting edge, and later changes do not affect the scan in progress. A start asserted during a scan is ignored, and the result still appears 17 edges after the original start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a new scan (accepted when idle or done) |
| scheme_sel | input | 1 | 0 = matrix scheme, 1 = select scheme |
| code_sel_in | input | 1 | Shared code-select return level |
| strap_in | input | 1 | Pull-up strap level of the driven line |
| line_drive | output | 8 | One-hot select line drive |
| code_hi | output | 8 | Primary custom code byte, bit n = Cn |
| code_lo | output | 8 | Check custom code byte, bit n = Cn' |
| code_valid | output | 1 | Resolved code is held on `code_hi`/`code_lo` |
| multi_conn_err | output | 1 | Several lines read connected in select scheme |

## Verification
A line index that advances wrongly, or a missing settle cycle, shows on `line_drive` within one cycle of the fault. It also moves the rising edge of `code_valid` away from edge 17. A sample captured into the wrong slot, or a decode error in either scheme, stays hidden until `code_valid` rises. The output bytes then differ from the arithmetic model for most strap patterns. For this reason the sweep covers every matrix connection pattern and every single, absent and multiple select connection across strap combinations. A scheme latch that follows its input live only shows up when `scheme_sel` is changed during a scan, so that case is driven on purpose.

// File: rtl/cc_resolver_pkg.sv
package cc_resolver_pkg;

    localparam int CC_LINES = 8;
    localparam int CC_IDX_W = $clog2(CC_LINES);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_SAMPLE,
        ST_RESOLVE,
        ST_DONE
    } scan_state_t;

    typedef enum logic {
        SCHEME_MATRIX = 1'b0,
        SCHEME_SELECT = 1'b1
    } scheme_t;

    // Upper five primary bits (C7..C3) from the straps of lines 7 and 6.
    function automatic logic [4:0] upper_from_straps(input logic s7, input logic s6);
        logic [4:0] r;
        unique case ({s7, s6})
            2'b00:   r = 5'b00000;
            2'b10:   r = 5'b10011;
            2'b01:   r = 5'b10001;
            default: r = 5'b11101;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cc_scan_fsm.sv
module cc_scan_fsm
    import cc_resolver_pkg::*;
#(
    parameter int LINES = CC_LINES,
    parameter int IDX_W = CC_IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic [LINES-1:0] line_drive,
    output logic [IDX_W-1:0] line_idx,
    output logic             cap_en,
    output logic             load_en,
    output logic             accept
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINES - 1);

    scan_state_t state, state_nx;
    logic        last_line;

    assign last_line = (line_idx == LAST_IDX);
    assign accept    = start && (state == ST_IDLE || state == ST_DONE);

    // State register and line index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            line_idx <= '0;
        end else begin
            state <= state_nx;
            if (accept)
                line_idx <= '0;
            else if (state == ST_SAMPLE && !last_line)
                line_idx <= line_idx + 1'b1;
        end
    end

    // Transitions: accept, settle_done, next_line, last_line, publish.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (accept) state_nx = ST_SETTLE;
            ST_SETTLE:  state_nx = ST_SAMPLE;
            ST_SAMPLE:  state_nx = last_line ? ST_RESOLVE : ST_SETTLE;
            ST_RESOLVE: state_nx = ST_DONE;
            ST_DONE:    if (accept) state_nx = ST_SETTLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // Outputs of each state.
    always_comb begin
        line_drive = '0;
        cap_en     = 1'b0;
        load_en    = 1'b0;
        unique case (state)
            ST_SETTLE:  line_drive[line_idx] = 1'b1;
            ST_SAMPLE: begin
                line_drive[line_idx] = 1'b1;
                cap_en               = 1'b1;
            end
            ST_RESOLVE: load_en = 1'b1;
            default: ;
        endcase
    end

    AST_DRIVE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(line_drive)); // R2

    AST_SAMPLE_SAME_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SAMPLE) |-> $stable(line_drive)); // R2

    AST_SCAN_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETTLE && $past(state) == ST_SAMPLE)
            |-> (line_drive == ($past(line_drive) << 1))); // R2

endmodule

// File: rtl/cc_strap_capture.sv
module cc_strap_capture
    import cc_resolver_pkg::*;
#(
    parameter int LINES = CC_LINES,
    parameter int IDX_W = CC_IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  logic [IDX_W-1:0] line_idx,
    input  logic             code_sel_in,
    input  logic             strap_in,
    output logic [LINES-1:0] sel_bits,
    output logic [LINES-1:0] strap_bits
);

    for (genvar g = 0; g < LINES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sel_bits[g]   <= 1'b0;
                strap_bits[g] <= 1'b0;
            end else if (cap_en && line_idx == IDX_W'(g)) begin
                sel_bits[g]   <= code_sel_in;
                strap_bits[g] <= strap_in;
            end
        end
    end

endmodule

// File: rtl/cc_code_assemble.sv
module cc_code_assemble
    import cc_resolver_pkg::*;
#(
    parameter int LINES = CC_LINES,
    parameter int IDX_W = CC_IDX_W
) (
    input  logic [LINES-1:0] sel_bits,
    input  logic [LINES-1:0] strap_bits,
    input  scheme_t          scheme,
    output logic [LINES-1:0] hi_byte,
    output logic [LINES-1:0] lo_byte,
    output logic             multi_hit
);

    logic [IDX_W-1:0] first_idx;
    logic [LINES-1:0] ctrl;
    logic [IDX_W:0]   hits;

    // Lowest connected line wins; count connections for the error flag.
    always_comb begin
        first_idx = '0;
        hits      = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (sel_bits[i]) first_idx = IDX_W'(i);
            hits = hits + {{IDX_W{1'b0}}, sel_bits[i]};
        end
    end

    always_comb begin
        unique case (scheme)
            SCHEME_MATRIX: begin
                hi_byte   = sel_bits;
                ctrl      = strap_bits;
                multi_hit = 1'b0;
            end
            default: begin
                hi_byte   = {upper_from_straps(strap_bits[7], strap_bits[6]), first_idx};
                ctrl      = {2'b00, strap_bits[5:0]};
                multi_hit = (hits > 1);
            end
        endcase
        // Set control bit keeps the primary bit, clear control bit inverts it.
        lo_byte = ~(hi_byte ^ ctrl);
    end

endmodule

// File: rtl/cc_resolver.sv
module cc_resolver
    import cc_resolver_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       scheme_sel,
    input  logic       code_sel_in,
    input  logic       strap_in,
    output logic [7:0] line_drive,
    output logic [7:0] code_hi,
    output logic [7:0] code_lo,
    output logic       code_valid,
    output logic       multi_conn_err
);

    localparam int LINES = CC_LINES;
    localparam int IDX_W = CC_IDX_W;

    logic [IDX_W-1:0] line_idx;
    logic             cap_en, load_en, accept;
    logic [LINES-1:0] sel_bits, strap_bits, hi_byte, lo_byte;
    logic             multi_hit;
    scheme_t          scheme_q;

    cc_scan_fsm #(.LINES(LINES), .IDX_W(IDX_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .line_drive (line_drive),
        .line_idx   (line_idx),
        .cap_en     (cap_en),
        .load_en    (load_en),
        .accept     (accept)
    );

    cc_strap_capture #(.LINES(LINES), .IDX_W(IDX_W)) u_cap (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_en      (cap_en),
        .line_idx    (line_idx),
        .code_sel_in (code_sel_in),
        .strap_in    (strap_in),
        .sel_bits    (sel_bits),
        .strap_bits  (strap_bits)
    );

    cc_code_assemble #(.LINES(LINES), .IDX_W(IDX_W)) u_asm (
        .sel_bits   (sel_bits),
        .strap_bits (strap_bits),
        .scheme     (scheme_q),
        .hi_byte    (hi_byte),
        .lo_byte    (lo_byte),
        .multi_hit  (multi_hit)
    );

    // Scheme latch and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scheme_q       <= SCHEME_MATRIX;
            code_hi        <= '0;
            code_lo        <= '0;
            code_valid     <= 1'b0;
            multi_conn_err <= 1'b0;
        end else if (accept) begin
            scheme_q       <= scheme_t'(scheme_sel);
            code_valid     <= 1'b0;
            multi_conn_err <= 1'b0;
        end else if (load_en) begin
            code_hi        <= hi_byte;
            code_lo        <= lo_byte;
            multi_conn_err <= multi_hit;
            code_valid     <= 1'b1;
        end
    end

    AST_VALID_AFTER_LAST_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(code_valid) |-> ($past(line_drive, 2) == 8'h80)); // R3

    AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (code_valid && $past(code_valid)) |-> ($stable(code_hi) && $stable(code_lo))); // R3

    AST_ERR_SELECT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        multi_conn_err |-> (code_valid && scheme_q == SCHEME_SELECT)); // R9

    AST_SELECT_TOP_INVERTED: assert property (@(posedge clk) disable iff (!rst_n)
        (code_valid && scheme_q == SCHEME_SELECT) |-> (code_lo[7:6] == ~code_hi[7:6])); // R8

endmodule

// File: tb/test_cc_resolver.sv
`timescale 1ns/1ps
module test_cc_resolver;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       scheme_sel = 1'b0;
    logic [7:0] conn_mask = 8'h00;
    logic [7:0] pull_mask = 8'h00;
    logic       code_sel_in, strap_in;
    logic [7:0] line_drive, code_hi, code_lo;
    logic       code_valid, multi_conn_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    // Board model: returns follow whichever line is driven.
    assign code_sel_in = |(line_drive & conn_mask);
    assign strap_in    = |(line_drive & pull_mask);

    cc_resolver i_cc_resolver (
        .clk(clk), .rst_n(rst_n), .start(start), .scheme_sel(scheme_sel),
        .code_sel_in(code_sel_in), .strap_in(strap_in), .line_drive(line_drive),
        .code_hi(code_hi), .code_lo(code_lo), .code_valid(code_valid),
        .multi_conn_err(multi_conn_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected {err, hi, lo} from the requirements.
    function automatic logic [16:0] model(input logic m, input logic [7:0] c, input logic [7:0] p);
        logic [7:0] hi, ctrl;
        logic       err;
        int         cnt;
        logic [2:0] idx;
        if (!m) begin
            hi = c; ctrl = p; err = 1'b0;
        end else begin
            idx = 3'd0; cnt = 0;
            for (int i = 7; i >= 0; i--) if (c[i]) begin idx = 3'(i); cnt++; end
            case ({p[7], p[6]})
                2'b00: hi[7:3] = 5'b00000;
                2'b10: hi[7:3] = 5'b10011;
                2'b01: hi[7:3] = 5'b10001;
                default: hi[7:3] = 5'b11101;
            endcase
            hi[2:0] = idx;
            ctrl = p & 8'h3F;
            err = (cnt > 1);
        end
        return {err, hi, ~(hi ^ ctrl)};
    endfunction

    // Start a scan; return at the negedge after edge 17.
    task automatic run_scan(input logic m, input logic [7:0] c, input logic [7:0] p);
        scheme_sel = m; conn_mask = c; pull_mask = p;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (17) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset drive", {24'd0, line_drive}, 32'd0);
        check("R1 reset code", {15'd0, multi_conn_err, code_valid, code_hi, code_lo}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 after reset", {14'd0, line_drive == 8'd0, multi_conn_err, code_valid, code_hi, code_lo}, 32'h10000 << 2);
        check("R2 idle no drive", {24'd0, line_drive}, 32'd0);

        // R2 / R3: detailed timing of one scan.
        scheme_sel = 1'b0; conn_mask = 8'h51; pull_mask = 8'h11;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int j = 0; j < 17; j++) begin
            if (j < 16) check("R2 line order", {24'd0, line_drive}, 32'(8'h01 << (j / 2)));
            else        check("R2 drive off after scan", {24'd0, line_drive}, 32'd0);
            if (j == 16) check("R3 valid not early", {31'd0, code_valid}, 32'd0);
            @(negedge clk);
        end
        check("R3 valid at edge 17", {31'd0, code_valid}, 32'd1);
        check("R5 example code", {15'd0, multi_conn_err, code_hi, code_lo}, {15'd0, 17'h051BF});
        repeat (5) @(negedge clk);
        check("R3 valid held", {15'd0, code_valid, code_hi, code_lo}, {15'd0, 1'b1, 16'h51BF});
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        check("R3 start clears valid", {31'd0, code_valid}, 32'd0);
        repeat (17) @(negedge clk);

        // R10: scheme latched, start during scan ignored.
        scheme_sel = 1'b1; conn_mask = 8'h08; pull_mask = 8'h40;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (3) @(negedge clk);
        scheme_sel = 1'b0; start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (12) @(negedge clk);
        check("R10 no early valid", {31'd0, code_valid}, 32'd0);
        @(negedge clk);
        check("R10 latched scheme", {14'd0, code_valid, multi_conn_err, code_hi, code_lo},
              {14'd0, 1'b1, model(1'b1, 8'h08, 8'h40)});

        // R4 R5: matrix sweep.
        for (int d = 0; d < 256; d++) begin
            for (int k = 0; k < 4; k++) begin
                logic [7:0] p;
                p = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : (k == 2) ? 8'(d * 7 + 3) : 8'h11;
                run_scan(1'b0, 8'(d), p);
                check("R4 R5 matrix", {14'd0, code_valid, multi_conn_err, code_hi, code_lo},
                      {14'd0, 1'b1, model(1'b0, 8'(d), p)});
            end
        end

        // R6 R7 R8 R9: select sweep.
        for (int c = 0; c < 13; c++) begin
            logic [7:0] cm;
            case (c)
                0: cm = 8'h00;
                9: cm = 8'h0C;
                10: cm = 8'hA0;
                11: cm = 8'hFF;
                12: cm = 8'h81;
                default: cm = 8'h01 << (c - 1);
            endcase
            for (int k = 0; k < 64; k++) begin
                logic [7:0] p;
                p = {2'(k) ^ 2'(k >> 2), 6'(k)};
                run_scan(1'b1, cm, p);
                if (c >= 9)
                    check("R9 multi select", {14'd0, code_valid, multi_conn_err, code_hi, code_lo},
                          {14'd0, 1'b1, model(1'b1, cm, p)});
                else
                    check("R6 R7 R8 select", {14'd0, code_valid, multi_conn_err, code_hi, code_lo},
                          {14'd0, 1'b1, model(1'b1, cm, p)});
            end
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule